// File: doc/BRIEF.md
# Phase-Disposition Gate Pattern Generator for a Dual-Source Multilevel Cell

This block drives the six power switches of an inverter cell that has no H-bridge. The cell is built from two DC sources and six switches. The switches fall into two groups: a left group (S1, S3, S5) and a right group (S2, S4, S6). In each group exactly one switch conducts at a time.

A phase accumulator, stepped by a frequency-tuning word, reads a computed sine table. The sine is scaled by a modulation index, and the result is the reference. The reference is compared against a stack of in-phase triangular carriers, stacked in equal bands. The carriers are derived from the same phase, so exactly 39 carrier periods fit in one fundamental period. The number of carriers the reference lies above gives a signed output level. A registered decoder turns that level and the half-cycle sign into the gate pattern. A zero level uses a different null state in each half-cycle, which spreads conduction losses over the switches.

A mode input picks between two operating modes:
- Seven-level mode is for unequal sources. It uses six carriers.
- Five-level mode is for equal sources. It uses four carriers.

Top module: `mlpwm_gate_gen`

## Requirements
- R1: While `rst` is high, the gate output is the positive-half null pattern `6'b001100` (S3 and S4 on), and the phase accumulator is held at zero. Gate bit k-1 drives switch Sk.
- R2: In every cycle, exactly one of the bits {0, 2, 4} (S1, S3, S5) is set, and exactly one of the bits {1, 3, 5} (S2, S4, S6) is set.
- R3: In seven-level mode, the levels map to gate patterns as follows:
  - +1 gives `100100` (S3, S6).
  - +2 gives `010010` (S2, S5).
  - +3 gives `000110` (S2, S3).
  - -1 gives `011000` (S4, S5).
  - -2 gives `100001` (S1, S6).
  - -3 gives `001001` (S1, S4).
- R4: The null pattern depends on the half-cycle of the reference. Level 0 gives `001100` in the positive half-cycle and `000011` (S1, S2) in the negative half-cycle. The pattern with S5 and S6 both on never appears.
- R5: In five-level mode, the levels map to gate patterns as follows:
  - +1 gives `100100`.
  - +2 gives `000110`.
  - -1 gives `011000`.
  - -2 gives `001001`.
  The patterns `010010` and `100001` never appear in this mode.
- R6: With a modulation index of 243/256, one fundamental period produces every level. That is -3..+3 in seven-level mode and -2..+2 in five-level mode.
- R7: With a tuning word of 16 and the mode held constant, the level changes by at most one step between consecutive clock cycles.
- R8: Let the tuning word divide 2^16, and let P = 2^16 / tuning word. Then the level at cycle n+P/2 is the negative of the level at cycle n. A positive-half null at cycle n is matched by a negative-half null at cycle n+P/2, and the reverse.
- R9: The gate sequence repeats with a period of P cycles.
- R10: With a modulation index of zero, only the two null patterns appear, and both of them appear within one period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_i | input | 16 | Phase increment per clock (fundamental frequency) |
| mi_i | input | 8 | Modulation index, unsigned fraction of 256 |
| seven_i | input | 1 | 1 = seven-level mode (unequal sources), 0 = five-level mode |
| gate_o | output | 6 | Gate drives; bit k-1 is switch Sk |

## Verification
The bench sweeps two full fundamental periods under three stimulus patterns:
- Seven-level mode at index 0.95. This sweep exercises all six carriers and the asymmetric level-to-pattern table.
- Five-level mode at the same index. This sweep shows that the outer carriers are masked, and that the sum-of-sources patterns take over the ±2 levels.
- A zero index. This sweep isolates the half-cycle null selection from all carrier crossings.

Within each sweep, several checks compare the patterns against each other:
- Comparing each cycle with the cycle half a period later separates a correct sign and null flip from any offset or tie bias in the comparators.
- Comparing adjacent cycles catches wrong pattern assignments. A wrong assignment shows up as an impossible two-step jump.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

   typedef logic [5:0] gate_t;

   // bit k-1 drives switch Sk
   localparam gate_t G_NULL_POS = 6'b001100;
   localparam gate_t G_NULL_NEG = 6'b000011;
   localparam gate_t G_NULL_BAD = 6'b110000;
   localparam gate_t G_P_V2     = 6'b100100;
   localparam gate_t G_P_V1     = 6'b010010;
   localparam gate_t G_P_SUM    = 6'b000110;
   localparam gate_t G_N_V2     = 6'b011000;
   localparam gate_t G_N_V1     = 6'b100001;
   localparam gate_t G_N_SUM    = 6'b001001;

   // Half-wave sine magnitude by rational approximation, k in [0, half_n)
   function automatic int sine_mag(input int k, input int half_n, input int peak);
      int prod;
      prod = k * (half_n - k);
      return (16 * prod * peak) / (5 * half_n * half_n - 4 * prod);
   endfunction

endpackage

// File: rtl/mlpwm_phase_gen.sv
module mlpwm_phase_gen #(
   parameter int PH_W      = 16,
   parameter int CAR_RATIO = 39,
   parameter int TRI_W     = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PH_W-1:0]   ftw,
   output logic [PH_W-1:0]   phase,
   output logic [TRI_W-1:0]  tri_val
);
   localparam logic [PH_W-1:0] RATIO_V = PH_W'(CAR_RATIO);

   logic [PH_W-1:0] car_ph;

   always_ff @(posedge clk) begin
      if (rst) phase <= '0;
      else     phase <= phase + ftw;
   end

   // carrier phase runs CAR_RATIO times faster, wrapping in step with the fundamental
   assign car_ph  = phase * RATIO_V;
   assign tri_val = car_ph[PH_W-1] ? ~car_ph[PH_W-2 -: TRI_W] : car_ph[PH_W-2 -: TRI_W];

endmodule

// File: rtl/mlpwm_ref_gen.sv
module mlpwm_ref_gen #(
   parameter int PH_W   = 16,
   parameter int LUT_AW = 6,
   parameter int SINE_W = 10,
   parameter int MI_W   = 8,
   parameter int TRI_W  = 6,
   parameter int OFF_W  = TRI_W + 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PH_W-1:0]   phase,
   input  logic [TRI_W-1:0]  tri_in,
   input  logic [MI_W-1:0]   mi,
   input  logic              seven,
   output logic              neg_o,
   output logic [OFF_W-1:0]  off_o,
   output logic [TRI_W-1:0]  tri_o,
   output logic              seven_o
);
   import mlpwm_pkg::*;

   localparam int HALF   = 2 ** (LUT_AW - 1);
   localparam int BAND   = 2 ** TRI_W;
   localparam int PROD_W = SINE_W + 1 + MI_W + OFF_W;

   logic [SINE_W:0]       lut [HALF];
   logic [LUT_AW-1:0]     idx;
   logic [PROD_W-1:0]     prod;
   logic [OFF_W-1:0]      amp, mag;

   for (genvar g = 0; g < HALF; g++) begin : g_lut
      assign lut[g] = (SINE_W + 1)'(sine_mag(g, HALF, 2 ** SINE_W));
   end

   assign idx  = phase[PH_W-1 -: LUT_AW];
   assign amp  = seven ? OFF_W'(3 * BAND) : OFF_W'(2 * BAND);
   assign prod = PROD_W'(lut[idx[LUT_AW-2:0]]) * PROD_W'(mi) * PROD_W'(amp);
   assign mag  = OFF_W'(prod >> (SINE_W + MI_W));

   // datapath stage; recomputed from the cleared phase while reset is held
   always_ff @(posedge clk) begin
      neg_o   <= idx[LUT_AW-1];
      off_o   <= idx[LUT_AW-1] ? amp - mag : amp + mag;
      tri_o   <= tri_in;
      seven_o <= seven;
   end

   assert_ref_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      off_o <= (seven_o ? OFF_W'(6 * BAND) : OFF_W'(4 * BAND)));

endmodule

// File: rtl/mlpwm_level_cmp.sv
module mlpwm_level_cmp #(
   parameter int TRI_W = 6,
   parameter int OFF_W = TRI_W + 3,
   parameter int NCAR  = 6
) (
   input  logic              seven,
   input  logic [OFF_W-1:0]  off,
   input  logic [TRI_W-1:0]  tri_val,
   output logic signed [3:0] level
);
   localparam int BAND = 2 ** TRI_W;

   logic [NCAR-1:0] hit;
   logic [2:0]      cnt;

   // one comparator per carrier band; the outer pair is masked in five-level mode
   for (genvar j = 0; j < NCAR; j++) begin : g_car
      if (j >= 1 && j <= NCAR - 2) begin : g_inner
         assign hit[j] = (j <= 3 || seven) &&
                         (off > OFF_W'(j * BAND) + OFF_W'(tri_val));
      end else begin : g_outer
         assign hit[j] = (j == 0) ? (off > OFF_W'(tri_val))
                                  : (seven && (off > OFF_W'(j * BAND) + OFF_W'(tri_val)));
      end
   end

   always_comb begin
      cnt = '0;
      for (int j = 0; j < NCAR; j++) cnt = cnt + 3'(hit[j]);
   end

   assign level = $signed({1'b0, cnt}) - (seven ? 4'sd3 : 4'sd2);

endmodule

// File: rtl/mlpwm_state_dec.sv
module mlpwm_state_dec (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [3:0]   level,
   input  logic                neg,
   input  logic                seven,
   output mlpwm_pkg::gate_t    gates
);
   import mlpwm_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         gates <= G_NULL_POS;
      end else begin
         case (level)
            4'sd1:   gates <= G_P_V2;
            4'sd2:   gates <= seven ? G_P_V1 : G_P_SUM;
            4'sd3:   gates <= G_P_SUM;
            -4'sd1:  gates <= G_N_V2;
            -4'sd2:  gates <= seven ? G_N_V1 : G_N_SUM;
            -4'sd3:  gates <= G_N_SUM;
            default: gates <= neg ? G_NULL_NEG : G_NULL_POS;
         endcase
      end
   end

   assert_reset_null_R1: assert property (@(posedge clk)
      rst |=> gates == G_NULL_POS);
   assert_left_single_R2: assert property (@(posedge clk) disable iff (rst)
      $countones({gates[4], gates[2], gates[0]}) == 1);
   assert_right_single_R2: assert property (@(posedge clk) disable iff (rst)
      $countones({gates[5], gates[3], gates[1]}) == 1);
   assert_no_third_null_R4: assert property (@(posedge clk) disable iff (rst)
      gates != G_NULL_BAD);
   assert_five_no_single_v1_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(seven) |-> (gates != G_P_V1 && gates != G_N_V1));

endmodule

// File: rtl/mlpwm_gate_gen.sv
module mlpwm_gate_gen #(
   parameter int PH_W      = 16,
   parameter int MI_W      = 8,
   parameter int TRI_W     = 6,
   parameter int LUT_AW    = 6,
   parameter int SINE_W    = 10,
   parameter int CAR_RATIO = 39
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PH_W-1:0]  ftw_i,
   input  logic [MI_W-1:0]  mi_i,
   input  logic             seven_i,
   output logic [5:0]       gate_o
);
   localparam int OFF_W = TRI_W + 3;
   localparam int NCAR  = 6;

   if (CAR_RATIO % 2 == 0) begin : g_bad_ratio
      $error("CAR_RATIO must be odd for half-wave symmetry");
   end
   if (TRI_W + 2 > PH_W || LUT_AW < 3 || LUT_AW > PH_W) begin : g_bad_width
      $error("phase width too small for the carrier or sine index");
   end

   logic [PH_W-1:0]   phase;
   logic [TRI_W-1:0]  tri_c, tri_q;
   logic              neg_q, seven_q;
   logic [OFF_W-1:0]  off_q;
   logic signed [3:0] level;

   mlpwm_phase_gen #(.PH_W(PH_W), .CAR_RATIO(CAR_RATIO), .TRI_W(TRI_W)) u_phase (
      .clk(clk), .rst(rst), .ftw(ftw_i), .phase(phase), .tri_val(tri_c));

   mlpwm_ref_gen #(.PH_W(PH_W), .LUT_AW(LUT_AW), .SINE_W(SINE_W), .MI_W(MI_W),
                   .TRI_W(TRI_W), .OFF_W(OFF_W)) u_ref (
      .clk(clk), .rst(rst), .phase(phase), .tri_in(tri_c), .mi(mi_i), .seven(seven_i),
      .neg_o(neg_q), .off_o(off_q), .tri_o(tri_q), .seven_o(seven_q));

   mlpwm_level_cmp #(.TRI_W(TRI_W), .OFF_W(OFF_W), .NCAR(NCAR)) u_cmp (
      .seven(seven_q), .off(off_q), .tri_val(tri_q), .level(level));

   mlpwm_state_dec u_dec (
      .clk(clk), .rst(rst), .level(level), .neg(neg_q), .seven(seven_q), .gates(gate_o));

endmodule

// File: tb/mlpwm_gate_gen_tb.sv
module mlpwm_gate_gen_tb;

   localparam int FTW  = 16;
   localparam int P    = 65536 / FTW;
   localparam int SKIP = 8;

   typedef struct {
      int       lvl;
      bit       is_null;
      bit [5:0] pat;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] ftw_i = 16'(FTW);
   logic [7:0]  mi_i = 8'd243;
   logic        seven_i = 1'b1;
   logic [5:0]  gate_o;

   int checks = 0;
   int fails  = 0;
   exp_t     sym_q[$];
   bit [5:0] hist[P];

   always #4 clk = ~clk;

   mlpwm_gate_gen u_dut (.clk(clk), .rst(rst), .ftw_i(ftw_i), .mi_i(mi_i),
                         .seven_i(seven_i), .gate_o(gate_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // level from a gate pattern per the R3 / R4 / R5 tables
   function automatic int decode(input bit [5:0] g, input bit seven, output bit legal);
      legal = 1'b1;
      case (g)
         6'b001100, 6'b000011: return 0;
         6'b100100: return 1;
         6'b011000: return -1;
         6'b000110: return seven ? 3 : 2;
         6'b001001: return seven ? -3 : -2;
         6'b010010: begin legal = seven; return 2; end
         6'b100001: begin legal = seven; return -2; end
         default: begin legal = 1'b0; return 0; end
      endcase
   endfunction

   task automatic restart(input bit seven, input bit [7:0] mi);
      @(negedge clk);
      rst = 1'b1; seven_i = seven; mi_i = mi;
      repeat (4) @(negedge clk);
      chk(gate_o == 6'b001100, "R1 reset null", int'(gate_o), 12);
      rst = 1'b0;
      repeat (SKIP) @(negedge clk);
   endtask

   task automatic sweep(input bit seven, input bit [7:0] mi);
      bit seen[7];
      bit seen_pos_null, seen_neg_null, legal;
      int lvl, prev;
      exp_t e;
      foreach (seen[i]) seen[i] = 1'b0;
      seen_pos_null = 1'b0; seen_neg_null = 1'b0; prev = 0;
      sym_q.delete();
      restart(seven, mi);
      for (int n = 0; n < 2 * P; n++) begin
         @(negedge clk);
         lvl = decode(gate_o, seven, legal);
         chk(legal, seven ? "R2 R3 legal seven-level pattern" : "R2 R5 legal five-level pattern",
             int'(gate_o), 0);
         if (n > 0) chk(lvl - prev <= 1 && prev - lvl <= 1, "R7 single step", lvl, prev);
         prev = lvl;
         seen[lvl + 3] = 1'b1;
         if (gate_o == 6'b001100) seen_pos_null = 1'b1;
         if (gate_o == 6'b000011) seen_neg_null = 1'b1;
         if (n < P) hist[n] = gate_o;
         else chk(gate_o == hist[n - P], "R9 periodic", int'(gate_o), int'(hist[n - P]));
         if (n < P / 2) begin
            e.lvl = -lvl;
            e.is_null = (lvl == 0);
            e.pat = (gate_o == 6'b001100) ? 6'b000011 : 6'b001100;
            sym_q.push_back(e);
         end else if (n < P) begin
            e = sym_q.pop_front();
            chk(lvl == e.lvl, "R8 mirrored level", lvl, e.lvl);
            if (e.is_null) chk(gate_o == e.pat, "R4 R8 null flips with half-cycle",
                               int'(gate_o), int'(e.pat));
         end
      end
      if (mi == 8'd0) begin
         for (int i = 0; i < 7; i++)
            if (i != 3) chk(!seen[i], "R10 zero index stays null", i - 3, 0);
         chk(seen_pos_null && seen_neg_null, "R10 R4 both nulls used",
             int'(seen_pos_null) + int'(seen_neg_null), 2);
      end else begin
         for (int i = 0; i < 7; i++) begin
            if (seven || (i >= 1 && i <= 5))
               chk(seen[i], "R6 level reached", 0, i - 3);
            else
               chk(!seen[i], "R5 five-level range", i - 3, 0);
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      sweep(1'b1, 8'd243);
      sweep(1'b0, 8'd243);
      sweep(1'b1, 8'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule